// File: doc/BRIEF.md
# Framed Serial Packet Transmitter

This block takes one packet at a time from a parallel source and sends it as a framed bit-serial stream into one input port of a packet router. A packet is described by a destination address and a byte count on a start handshake; its payload bytes then arrive one by one on a separate valid/ready byte stream. On the serial side the block drives an active-low frame line, an active-low bit-valid line and a data line. It also obeys the receiving port's active-low busy indication before it begins the payload.

The serial frame has three phases. In the first, the frame line is low and the destination address is shifted out least significant bit first, one bit per clock. In the second, a fixed pad of a set number of cycles holds the data line at one with bit-valid inactive. In the third, once the receiver is free, the payload bytes go out least significant bit first with bit-valid active. The frame line rises on the final payload bit. In the cycle after that bit, the line is back to idle and a one-cycle done pulse marks the end of the packet.

Back-pressure: `start_ready` is high only while the block is idle, so a new packet can only be accepted between frames. `byte_ready` is high only while a packet is in its pad, busy-wait or payload phase, the holding register is free or being emptied in that same cycle, and fewer bytes than the packet's count have been taken. A byte moves on a clock edge where `byte_valid` and `byte_ready` are both high. If the source is late with a byte, the serial line pauses and no bit is lost.

Top module: `pkt_serial_tx`

## Requirements
- R1: While reset is held and right after it, ser_frame_n=1, ser_valid_n=1, ser_data=0, start_ready=1, byte_ready=0, done=0 and err=0.
- R2: start_ready is 1 only when the block is idle. A start request whose start_len lies outside 1..MAX_LEN (for example 0 or 11) gets err=1 for exactly the next cycle and sends no frame. The line stays idle and start_ready stays 1.
- R3: In the cycle after an accepted start, ser_frame_n goes to 0. For ADDR_W cycles, ser_data carries start_dest with bit 0 first, while ser_valid_n stays 1.
- R4: Right after the address comes a pad with ser_data=1, ser_valid_n=1 and ser_frame_n=0. When dest_busy_n is 1, the pad lasts exactly PAD_CYC cycles and the first payload bit follows at once.
- R5: The payload starts only after dest_busy_n is sampled 1 on the clock edge that ends the pad or on a later edge. While dest_busy_n stays 0, the pad level is held.
- R6: Payload bits go out with ser_valid_n=0, bit 0 of each byte first, with the bytes in the order they were taken from the byte stream. Exactly 8*start_len valid bits are sent.
- R7: ser_frame_n is 1 during the final payload bit only. In the following cycle, ser_valid_n and ser_frame_n are both 1.
- R8: If the next byte has not arrived during the payload, ser_valid_n=1 and ser_frame_n=0 are held, and the bit position does not advance until the byte arrives.
- R9: done is 1 for exactly one cycle: the cycle right after the final payload bit.
- R10: byte_ready is 0 while idle, and at most start_len bytes are taken for a packet. Bytes offered outside a frame, or beyond the count, stay with the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Packet start request |
| start_ready | output | 1 | Block idle, start can be taken |
| start_dest | input | ADDR_W | Destination address of the packet |
| start_len | input | LEN_W | Payload byte count, legal range 1..MAX_LEN |
| byte_valid | input | 1 | Payload byte offered |
| byte_ready | output | 1 | Payload byte can be taken |
| byte_data | input | DATA_W | Payload byte |
| dest_busy_n | input | 1 | Receiver busy, active low |
| ser_frame_n | output | 1 | Frame line, active low |
| ser_valid_n | output | 1 | Payload bit valid, active low |
| ser_data | output | 1 | Serial data line |
| done | output | 1 | One-cycle end-of-packet pulse |
| err | output | 1 | One-cycle illegal-count pulse |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 8-bit bytes, a 10-byte maximum and a 5-cycle pad. With these values both count limits (1 and 10) and the illegal counts just outside them (0 and 11) can be reached with the 4-bit count port. A held busy line stretches the pad by a known number of cycles. A byte source that pauses mid-packet exposes the stall between bytes. An extra byte left queued after a short packet shows that the count limits how many bytes are taken.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_PAD  = 3'd2,
    PH_WAIT = 3'd3,
    PH_PAY  = 3'd4
  } ptx_phase_e;

  function automatic int unsigned pmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ptx_seq.sv
module ptx_seq
  import pkt_tx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 10,
  parameter int PAD_CYC = 5,
  parameter int LEN_W   = 4,
  parameter int CNT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_dest,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              dest_busy_n,
  input  logic              have,
  output logic              start_ready,
  output logic              accept,
  output ptx_phase_e        phase,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] dest,
  output logic [LEN_W-1:0]  len,
  output logic              last_byte,
  output logic              consume,
  output logic              done,
  output logic              err
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_LEN);

  ptx_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] dest_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  sent_q;
  logic              done_q;
  logic              err_q;
  logic              len_ok;
  logic              idle;
  logic              reject;

  assign idle      = (phase_q == PH_IDLE);
  assign len_ok    = (start_len != '0) && (start_len <= LEN_MAX);
  assign accept    = start_valid && idle && len_ok;
  assign reject    = start_valid && idle && !len_ok;
  assign last_byte = (sent_q == (len_q - LEN_W'(1)));
  assign consume   = (phase_q == PH_PAY) && have && (cnt_q == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dest_q  <= '0;
      len_q   <= '0;
      sent_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            dest_q  <= start_dest;
            len_q   <= start_len;
            sent_q  <= '0;
          end
        end
        PH_ADDR: begin
          if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            phase_q <= PH_PAD;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_PAD: begin
          if (cnt_q == PAD_LAST) begin
            cnt_q   <= '0;
            phase_q <= dest_busy_n ? PH_PAY : PH_WAIT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_WAIT: begin
          if (dest_busy_n) begin
            phase_q <= PH_PAY;
          end
        end
        PH_PAY: begin
          if (have) begin
            if (cnt_q == BIT_LAST) begin
              cnt_q <= '0;
              if (last_byte) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                sent_q <= sent_q + LEN_W'(1);
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign start_ready = idle;
  assign phase       = phase_q;
  assign cnt         = cnt_q;
  assign dest        = dest_q;
  assign len         = len_q;
  assign done        = done_q;
  assign err         = err_q;

endmodule

// File: rtl/ptx_byte_buf.sv
module ptx_byte_buf #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              fill_en,
  input  logic [LEN_W-1:0]  len,
  input  logic              consume,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              have,
  output logic [DATA_W-1:0] cur
);

  logic [DATA_W-1:0] cur_q;
  logic              have_q;
  logic [LEN_W-1:0]  taken_q;
  logic              take;

  assign byte_ready = fill_en && (taken_q < len) && (!have_q || consume);
  assign take       = byte_valid && byte_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      have_q  <= 1'b0;
      taken_q <= '0;
    end else if (accept) begin
      have_q  <= 1'b0;
      taken_q <= '0;
    end else if (take) begin
      cur_q   <= byte_data;
      have_q  <= 1'b1;
      taken_q <= taken_q + LEN_W'(1);
    end else if (consume) begin
      have_q <= 1'b0;
    end
  end

  assign have = have_q;
  assign cur  = cur_q;

endmodule

// File: rtl/ptx_line.sv
module ptx_line
  import pkt_tx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  ptx_phase_e        phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] dest,
  input  logic [DATA_W-1:0] cur,
  input  logic              have,
  input  logic              last_byte,
  output logic              frame_n,
  output logic              valid_n,
  output logic              data
);

  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [ADDR_W-1:0] dest_sh;
  logic [DATA_W-1:0] cur_sh;

  assign dest_sh = dest >> cnt;
  assign cur_sh  = cur >> cnt;

  always_comb begin
    frame_n = 1'b1;
    valid_n = 1'b1;
    data    = 1'b0;
    unique case (phase)
      PH_ADDR: begin
        frame_n = 1'b0;
        data    = dest_sh[0];
      end
      PH_PAD, PH_WAIT: begin
        frame_n = 1'b0;
        data    = 1'b1;
      end
      PH_PAY: begin
        if (have) begin
          valid_n = 1'b0;
          data    = cur_sh[0];
          frame_n = last_byte && (cnt == BIT_LAST);
        end else begin
          frame_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pkt_serial_tx.sv
module pkt_serial_tx
  import pkt_tx_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 10,
  parameter int PAD_CYC = 5,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_dest,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              dest_busy_n,
  output logic              ser_frame_n,
  output logic              ser_valid_n,
  output logic              ser_data,
  output logic              done,
  output logic              err
);

  localparam int CNT_RAW = $clog2(pmax(pmax(ADDR_W, PAD_CYC), DATA_W));
  localparam int CNT_W   = (CNT_RAW < 1) ? 1 : CNT_RAW;

  ptx_phase_e        phase;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] dest;
  logic [LEN_W-1:0]  len;
  logic [DATA_W-1:0] cur;
  logic              accept;
  logic              have;
  logic              last_byte;
  logic              consume;
  logic              fill_en;

  assign fill_en = (phase == PH_PAD) || (phase == PH_WAIT) || (phase == PH_PAY);

  ptx_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MAX_LEN(MAX_LEN),
    .PAD_CYC(PAD_CYC),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_dest (start_dest),
    .start_len  (start_len),
    .dest_busy_n(dest_busy_n),
    .have       (have),
    .start_ready(start_ready),
    .accept     (accept),
    .phase      (phase),
    .cnt        (cnt),
    .dest       (dest),
    .len        (len),
    .last_byte  (last_byte),
    .consume    (consume),
    .done       (done),
    .err        (err)
  );

  ptx_byte_buf #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .fill_en   (fill_en),
    .len       (len),
    .consume   (consume),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .byte_ready(byte_ready),
    .have      (have),
    .cur       (cur)
  );

  ptx_line #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_line (
    .phase    (phase),
    .cnt      (cnt),
    .dest     (dest),
    .cur      (cur),
    .have     (have),
    .last_byte(last_byte),
    .frame_n  (ser_frame_n),
    .valid_n  (ser_valid_n),
    .data     (ser_data)
  );

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker (
  input logic clk,
  input logic rst_n,
  input logic ser_frame_n,
  input logic ser_valid_n,
  input logic done,
  input logic err,
  input logic start_ready,
  input logic byte_ready
);

  a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid_n && ser_frame_n) |=> (ser_valid_n && ser_frame_n));

  a_r9_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!ser_valid_n && ser_frame_n));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_err_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ser_frame_n && ser_valid_n && start_ready));

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (ser_frame_n && ser_valid_n));

  a_r10_byte_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !ser_frame_n);

  a_r3_frame_opens_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_frame_n) |-> ser_valid_n);

endmodule

bind pkt_serial_tx ptx_checker u_ptx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_frame_n(ser_frame_n),
  .ser_valid_n(ser_valid_n),
  .done       (done),
  .err        (err),
  .start_ready(start_ready),
  .byte_ready (byte_ready)
);

// File: tb/test_pkt_serial_tx.sv
`timescale 1ns/1ps
module test_pkt_serial_tx;

  typedef struct {
    logic [3:0] dest;
    int         len;
    logic [7:0] b [10];
    int         gap;
    bit         stall;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic       start_ready;
  logic [3:0] start_dest = '0;
  logic [3:0] start_len = '0;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [7:0] byte_data = '0;
  logic       dest_busy_n = 1'b1;
  logic       ser_frame_n, ser_valid_n, ser_data, done, err;

  int total = 0;
  int bad = 0;
  int pkt_seen = 0;
  bit starve = 1'b0;
  bit finished = 1'b0;
  exp_t expq[$];
  logic [7:0] feedq[$];

  always #2.5 clk = ~clk;

  pkt_serial_tx i_pkt_serial_tx (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_dest(start_dest), .start_len(start_len),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .dest_busy_n(dest_busy_n),
    .ser_frame_n(ser_frame_n), .ser_valid_n(ser_valid_n), .ser_data(ser_data),
    .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // byte source: decides at the falling edge what the next rising edge takes
  initial begin
    bit take_pend = 1'b0;
    forever begin
      @(negedge clk);
      if (take_pend && feedq.size() > 0) void'(feedq.pop_front());
      byte_valid = (feedq.size() > 0) && !starve;
      byte_data  = byte_valid ? feedq[0] : 8'h00;
      take_pend  = byte_valid && byte_ready;
    end
  end

  // monitor: rebuilds each frame from the line and compares with the scoreboard
  initial begin
    logic [3:0] addr;
    logic [7:0] rb [10];
    int nb, gap, stl;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && !ser_frame_n) begin
        chk(start_ready == 1'b0, "R2 ready low in frame", int'(start_ready), 0);
        chk(ser_valid_n == 1'b1, "R3 valid high in address", int'(ser_valid_n), 1);
        addr[0] = ser_data;
        for (int i = 1; i < 4; i++) begin
          @(negedge clk);
          addr[i] = ser_data;
        end
        gap = 0;
        @(negedge clk);
        while (ser_valid_n) begin
          if (!(ser_data && !ser_frame_n))
            chk(1'b0, "R4 pad level", int'({ser_frame_n, ser_data}), 1);
          gap++;
          @(negedge clk);
        end
        nb = 0;
        stl = 0;
        for (int i = 0; i < 10; i++) rb[i] = '0;
        forever begin
          if (!ser_valid_n) begin
            if (nb < 80) rb[nb/8][nb%8] = ser_data;
            nb++;
            if (ser_frame_n) break;
          end else begin
            if (ser_frame_n) chk(1'b0, "R8 frame low in stall", 1, 0);
            stl++;
          end
          @(negedge clk);
        end
        @(negedge clk);
        chk(ser_valid_n && ser_frame_n, "R7 release after last bit",
            int'({ser_frame_n, ser_valid_n}), 3);
        chk(done == 1'b1, "R9 done after last bit", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", 1, 0);
        end else begin
          e = expq.pop_front();
          chk(addr == e.dest, "R3 address", int'(addr), int'(e.dest));
          chk(nb == 8 * e.len, "R6 bit count", nb, 8 * e.len);
          for (int i = 0; i < e.len; i++)
            chk(rb[i] == e.b[i], "R6 payload byte", int'(rb[i]), int'(e.b[i]));
          if (e.gap >= 0) chk(gap == e.gap, "R4 R5 pad length", gap, e.gap);
          if (e.stall) chk(stl > 0, "R8 stall seen", stl, 1);
          else         chk(stl == 0, "R8 no stall", stl, 0);
        end
        pkt_seen++;
      end
    end
  end

  task automatic send_pkt(input logic [3:0] dest, input int len, input int seed,
                          input int busy_at, input int st_on, input int st_off,
                          input int gap_exp, input bit stall_exp, input bit extra);
    exp_t e;
    int seen0;
    e.dest = dest;
    e.len = len;
    for (int i = 0; i < 10; i++) e.b[i] = 8'(seed * 13 + i * 37 + 11);
    e.gap = gap_exp;
    e.stall = stall_exp;
    expq.push_back(e);
    for (int i = 0; i < len; i++) feedq.push_back(e.b[i]);
    if (extra) feedq.push_back(8'hEE);
    seen0 = pkt_seen;
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    if (busy_at >= 0) dest_busy_n = 1'b0;
    start_valid = 1'b1;
    start_dest = dest;
    start_len = 4'(len);
    @(posedge clk);
    for (int k = 0; k <= 40; k++) begin
      @(negedge clk);
      if (k == 0) start_valid = 1'b0;
      if (k == busy_at) dest_busy_n = 1'b1;
      if (k == st_on) starve = 1'b1;
      if (k == st_off) starve = 1'b0;
    end
    while (pkt_seen == seen0) @(negedge clk);
    if (extra) begin
      chk(feedq.size() == 1, "R10 extra byte left", feedq.size(), 1);
      feedq.delete();
    end
  endtask

  task automatic bad_len(input logic [3:0] l);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    start_dest = 4'h7;
    start_len = l;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    chk(err == 1'b1, "R2 err pulse", int'(err), 1);
    chk(start_ready == 1'b1, "R2 stays idle", int'(start_ready), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(err == 1'b0 && ser_frame_n && ser_valid_n, "R2 no frame after reject",
          int'({err, ser_frame_n, ser_valid_n}), 3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_frame_n && ser_valid_n && !ser_data, "R1 line in reset",
        int'({ser_frame_n, ser_valid_n, ser_data}), 6);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready && !byte_ready && !done && !err, "R1 handshake after reset",
        int'({start_ready, byte_ready, done, err}), 8);

    // R10: a byte offered while idle is not taken
    feedq.push_back(8'h5A);
    repeat (3) @(negedge clk);
    chk(byte_ready == 1'b0, "R10 no ready when idle", int'(byte_ready), 0);
    chk(feedq.size() == 1, "R10 idle byte kept", feedq.size(), 1);
    feedq.delete();
    @(negedge clk);

    send_pkt(4'hA, 1, 1, -1, -1, -1, 5, 1'b0, 1'b1);   // R3 R4 R6 R7 R9 R10 minimum count
    send_pkt(4'h3, 10, 2, -1, -1, -1, 5, 1'b0, 1'b0);  // R6 maximum count
    bad_len(4'd0);                                     // R2 below range
    bad_len(4'd11);                                    // R2 above range
    send_pkt(4'h5, 2, 3, 11, -1, -1, 8, 1'b0, 1'b0);   // R5 busy holds pad to 8 cycles
    send_pkt(4'hC, 3, 4, -1, 6, 18, 5, 1'b1, 1'b0);    // R8 byte source pauses
    send_pkt(4'h0, 4, 5, -1, -1, -1, 5, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R3 all frames seen", expq.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9: actual=%0d expected=%0d", pkt_seen, 5);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule